// File: doc/BRIEF.md
# Isolated PWM Pulse Encoder

This block turns a current-mode PWM on-time into a differential drive pair for one pulse transformer. In encoded mode the pair swings in a complementary way every switching period. The positive phase starts when the period starts, which is also when the primary switches turn on. The negative phase starts at the maximum-duty point. The winding therefore carries bias power and gate timing at the same time. The end of the on-time is not sent as an edge. It is sent as a short window, counted in system-clock cycles, during which both drive pins sit at the same level. The receiving side sees this as zero volts across the winding.

A period strobe starts each period and a terminate request from the current comparator ends the on-time. A select input picks the maximum-duty point at one half or three quarters of the period. A mode input switches to bypass: the positive pin then carries the plain PWM waveform and the negative pin carries a period clock. The forward-switch gate follows the on-time and the synchronous gate is its complement. An overvoltage input forces the synchronous gate on and the forward gate off at once.

Top module: `pulse_encoder`

## Requirements
- R1: While reset is asserted, after the run enable has been low for two clock edges, and before the first period strobe, drvPos, drvNeg, fwdGate and syncGate are all 0. This holds whatever the overvoltage input does.
- R2: In encoded mode, a period strobe sampled at a clock edge makes drvPos=1, drvNeg=0, fwdGate=1 and syncGate=0 from the following edge onward.
- R3: The positive phase lasts PERIOD_CYC/2 cycles when dutySel=0 and (3*PERIOD_CYC)/4 cycles when dutySel=1. After that, drvPos=0, drvNeg=1, fwdGate=0 and syncGate=1 until the next strobe. A terminate request sampled on the maximum-duty edge has no effect.
- R4: In encoded mode, the first terminate request sampled during the positive phase drives drvPos and drvNeg both to 0 for ZERO_CYC cycles, starting one edge after the sampling edge. drvPos then returns to 1 until the maximum-duty point. fwdGate falls to 0 and syncGate rises to 1 in the same cycle the window opens.
- R5: A terminate request sampled together with the period strobe gives 0% duty. The zero window opens in the first cycle of the period and fwdGate stays 0 for the whole period.
- R6: With no terminate request, drvPos stays 1 with no zero window for the whole positive phase, and fwdGate stays 1 for the same cycles.
- R7: Only the first terminate request in a period is honoured. Later requests in the positive phase, and any request in the negative phase, leave all four outputs unchanged.
- R8: A zero window still open at the maximum-duty point is cut short. The negative phase (drvPos=0, drvNeg=1) starts at that point as usual.
- R9: With encodeEn=0 (bypass), drvPos equals the fwdGate waveform. drvNeg is 1 for the first PERIOD_CYC/2 cycles of each period and 0 for the rest, whatever dutySel is.
- R10: While the block is running, ovp=1 forces syncGate=1 and fwdGate=0 in the same cycle, with no clock edge in between. When ovp returns to 0, the gates return to their normal values.
- R11: In encoded mode, drvPos and drvNeg are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| runEn | input | 1 | Run enable; 0 shuts the block down |
| periodStrobe | input | 1 | One-cycle pulse that starts a switching period |
| pwmTerm | input | 1 | Terminate request from the current comparator |
| encodeEn | input | 1 | 1 = encoded drive, 0 = bypass (plain PWM and clock) |
| dutySel | input | 1 | Maximum duty: 0 = one half, 1 = three quarters of the period |
| ovp | input | 1 | Output overvoltage flag |
| drvPos | output | 1 | Positive transformer drive pin |
| drvNeg | output | 1 | Negative transformer drive pin |
| fwdGate | output | 1 | Forward-switch gate |
| syncGate | output | 1 | Synchronous-switch gate |

## Verification
The bench places terminate requests at offset zero, in the middle of the positive phase, right on the maximum-duty edge, late enough that the window crosses the maximum-duty point, and a second time in the same period, both in the positive and in the negative phase. A design that counts the window one cycle off, lets a second request re-open the window, drops the 0% case, or holds the window past the maximum-duty point shows a wrong level on drvPos or drvNeg in a specific cycle. A design that swaps the half and three-quarter points, leaves the bypass clock tied to the duty select, or delays the overvoltage override by a register is caught on the gate and drive pins in the cycle where that error first shows.

// File: rtl/pulse_enc_pkg.sv
package pulse_enc_pkg;

  // Strobes and phase state handed from the period control to the datapath
  typedef struct packed {
    logic active;     // a period has started and the block is enabled
    logic posPhase;   // positive half of the encoded waveform
    logic clkHigh;    // first half of the period (bypass clock)
    logic fwdOn;      // on-time in progress
    logic startZero;  // open a zero-differential window this edge
    logic cancelZero; // close any open window this edge
  } encCtl_t;

endpackage

// File: rtl/pulse_enc_ctrl.sv
module pulse_enc_ctrl
  import pulse_enc_pkg::*;
#(
  parameter int PERIOD_CYC = 100
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    runEn,
  input  logic    periodStrobe,
  input  logic    pwmTerm,
  input  logic    dutySel,
  output encCtl_t ctl
);

  localparam int CNT_W   = $clog2(PERIOD_CYC + 1);
  localparam int HALF_PT = PERIOD_CYC / 2;
  localparam int MAX3_PT = (PERIOD_CYC * 3) / 4;

  logic [CNT_W-1:0] cnt;
  logic active, posPhase, clkHigh, fwdOn, termDone;
  logic [CNT_W-1:0] maxPtM1;
  logic strobeGo, maxEdge, halfEdge, termGo;

  always_comb begin
    maxPtM1  = dutySel ? CNT_W'(MAX3_PT - 1) : CNT_W'(HALF_PT - 1);
    strobeGo = runEn & periodStrobe;
    maxEdge  = runEn & active & posPhase & ~periodStrobe & (cnt == maxPtM1);
    halfEdge = runEn & active & clkHigh & ~periodStrobe & (cnt == CNT_W'(HALF_PT - 1));
    termGo   = runEn & active & posPhase & ~termDone & pwmTerm & ~periodStrobe & ~maxEdge;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      active   <= 1'b0;
      posPhase <= 1'b0;
      clkHigh  <= 1'b0;
      fwdOn    <= 1'b0;
      termDone <= 1'b0;
    end else if (!runEn) begin
      cnt      <= '0;
      active   <= 1'b0;
      posPhase <= 1'b0;
      clkHigh  <= 1'b0;
      fwdOn    <= 1'b0;
      termDone <= 1'b0;
    end else if (periodStrobe) begin
      cnt      <= '0;
      active   <= 1'b1;
      posPhase <= 1'b1;
      clkHigh  <= 1'b1;
      fwdOn    <= ~pwmTerm;
      termDone <= pwmTerm;
    end else if (active) begin
      if (cnt != CNT_W'(PERIOD_CYC)) cnt <= cnt + 1'b1;
      if (maxEdge) begin
        posPhase <= 1'b0;
        fwdOn    <= 1'b0;
        termDone <= 1'b1;
      end
      if (halfEdge) clkHigh <= 1'b0;
      if (termGo) begin
        fwdOn    <= 1'b0;
        termDone <= 1'b1;
      end
    end
  end

  always_comb begin
    ctl            = '0;
    ctl.active     = active;
    ctl.posPhase   = posPhase;
    ctl.clkHigh    = clkHigh;
    ctl.fwdOn      = fwdOn;
    ctl.startZero  = (strobeGo & pwmTerm) | termGo;
    ctl.cancelZero = ~runEn | (strobeGo & ~pwmTerm) | maxEdge;
  end

  // R1: shutdown clears the period state
  a_r1_shutdown_clear: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> !active);

  // R3: the positive phase ends at the selected maximum-duty point
  a_r3_max_duty_end: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && active && !periodStrobe && posPhase && cnt == maxPtM1) |=> (!posPhase && !fwdOn));

  // R5: a request on the strobe edge gives 0% duty
  a_r5_zero_duty: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && periodStrobe && pwmTerm) |=> (!fwdOn && termDone && posPhase));

  // R7: once honoured, no further window opens in the same period
  a_r7_single_term: assert property (@(posedge clk) disable iff (!rstN)
    (termDone && !periodStrobe) |-> !ctl.startZero);

endmodule

// File: rtl/pulse_enc_dp.sv
module pulse_enc_dp
  import pulse_enc_pkg::*;
#(
  parameter int ZERO_CYC = 15
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    encodeEn,
  input  logic    ovp,
  input  encCtl_t ctl,
  output logic    drvPos,
  output logic    drvNeg,
  output logic    fwdGate,
  output logic    syncGate
);

  localparam int ZW_W = $clog2(ZERO_CYC + 1);

  logic [ZW_W-1:0] zeroCnt;
  logic zeroOn;
  logic posD, negD;
  logic posQ, negQ, fwdQ, syncQ, actQ, modeQ;

  // Zero-differential window length counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                zeroCnt <= '0;
    else if (ctl.startZero)   zeroCnt <= ZW_W'(ZERO_CYC);
    else if (ctl.cancelZero)  zeroCnt <= '0;
    else if (zeroCnt != '0)   zeroCnt <= zeroCnt - 1'b1;
  end

  assign zeroOn = (zeroCnt != '0);

  always_comb begin
    if (encodeEn) begin
      posD = ctl.active & ctl.posPhase & ~zeroOn;
      negD = ctl.active & ~ctl.posPhase;
    end else begin
      posD = ctl.active & ctl.fwdOn;
      negD = ctl.active & ctl.clkHigh;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      posQ  <= 1'b0;
      negQ  <= 1'b0;
      fwdQ  <= 1'b0;
      syncQ <= 1'b0;
      actQ  <= 1'b0;
      modeQ <= 1'b0;
    end else begin
      posQ  <= posD;
      negQ  <= negD;
      fwdQ  <= ctl.active & ctl.fwdOn;
      syncQ <= ctl.active & ~ctl.fwdOn;
      actQ  <= ctl.active;
      modeQ <= encodeEn;
    end
  end

  assign drvPos   = posQ;
  assign drvNeg   = negQ;
  assign fwdGate  = fwdQ & ~ovp;
  assign syncGate = syncQ | (ovp & actQ);

  // R4: a window opens at its full length
  a_r4_zero_load: assert property (@(posedge clk) disable iff (!rstN)
    ctl.startZero |=> (zeroCnt == ZW_W'(ZERO_CYC)));

  // R11: encoded drive pins never both high
  a_r11_never_both: assert property (@(posedge clk) disable iff (!rstN)
    modeQ |-> !(drvPos && drvNeg));

  // R10: overvoltage override on the gates
  a_r10_ovp_force: assert property (@(posedge clk) disable iff (!rstN)
    (ovp && actQ) |-> (syncGate && !fwdGate));

  // R1: idle means every output is low
  a_r1_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !actQ |-> !(drvPos || drvNeg || fwdGate || syncGate));

endmodule

// File: rtl/pulse_encoder.sv
module pulse_encoder
  import pulse_enc_pkg::*;
#(
  parameter int PERIOD_CYC = 100,
  parameter int ZERO_CYC   = 15
) (
  input  logic clk,
  input  logic rstN,
  input  logic runEn,
  input  logic periodStrobe,
  input  logic pwmTerm,
  input  logic encodeEn,
  input  logic dutySel,
  input  logic ovp,
  output logic drvPos,
  output logic drvNeg,
  output logic fwdGate,
  output logic syncGate
);

  encCtl_t ctl;

  pulse_enc_ctrl #(.PERIOD_CYC(PERIOD_CYC)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .runEn        (runEn),
    .periodStrobe (periodStrobe),
    .pwmTerm      (pwmTerm),
    .dutySel      (dutySel),
    .ctl          (ctl)
  );

  pulse_enc_dp #(.ZERO_CYC(ZERO_CYC)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .encodeEn (encodeEn),
    .ovp      (ovp),
    .ctl      (ctl),
    .drvPos   (drvPos),
    .drvNeg   (drvNeg),
    .fwdGate  (fwdGate),
    .syncGate (syncGate)
  );

endmodule

// File: tb/pulse_encoder_bench.sv
module pulse_encoder_bench;

  localparam int PER = 100;
  localparam int ZW  = 15;
  localparam int HALF = PER / 2;

  logic clk = 1'b0;
  logic rstN, runEn, periodStrobe, pwmTerm, encodeEn, dutySel, ovp;
  logic drvPos, drvNeg, fwdGate, syncGate;

  int cyc = 0;
  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  typedef struct {
    int        at;
    logic [3:0] exp;
    string     tag;
  } item_t;

  item_t sb[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pulse_encoder #(.PERIOD_CYC(PER), .ZERO_CYC(ZW)) u_pulse_encoder (
    .clk(clk), .rstN(rstN), .runEn(runEn), .periodStrobe(periodStrobe),
    .pwmTerm(pwmTerm), .encodeEn(encodeEn), .dutySel(dutySel), .ovp(ovp),
    .drvPos(drvPos), .drvNeg(drvNeg), .fwdGate(fwdGate), .syncGate(syncGate)
  );

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s at cycle %0d: {pos,neg,fwd,sync} got %b expected %b", tag, cyc, act, exp);
    end
  endtask

  // Expected {drvPos,drvNeg,fwdGate,syncGate} at cycle offset rel from the strobe drive cycle
  function automatic logic [3:0] expAt(int rel, bit enc, bit sel, int k);
    int  maxPt;
    bit  hon, fwd, zero, pos, neg;
    maxPt = sel ? (PER * 3) / 4 : PER / 2;
    hon   = (k >= 0) && (k < maxPt);
    fwd   = hon ? (rel <= k + 1) : (rel <= maxPt + 1);
    zero  = hon && (rel >= k + 2) && (rel <= k + 1 + ZW);
    if (enc) begin
      pos = (rel <= maxPt + 1) && !zero;
      neg = (rel >= maxPt + 2);
    end else begin
      pos = fwd;
      neg = (rel <= HALF + 1);
    end
    return {pos, neg, fwd, !fwd};
  endfunction

  // Driver: one period with up to two terminate requests (offset -1 = none)
  task automatic runPeriod(input bit enc, input bit sel, input int k, input int k2, input string tag);
    int s;
    s = cyc;
    for (int rel = 2; rel <= PER; rel++) begin
      item_t it;
      it.at  = s + rel;
      it.exp = expAt(rel, enc, sel, k);
      it.tag = tag;
      sb.push_back(it);
    end
    encodeEn = enc;
    dutySel  = sel;
    for (int i = 0; i < PER; i++) begin
      periodStrobe = (i == 0);
      pwmTerm      = (i == k) || (i == k2);
      @(negedge clk);
    end
    periodStrobe = 0;
    pwmTerm      = 0;
  endtask

  // Monitor: pop and compare items as their cycle comes up
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      item_t it;
      it = sb.pop_front();
      if (it.at < cyc) begin
        nChecks++;
        nFail++;
        $display("FAIL %s: item for cycle %0d missed, got %b expected %b", it.tag, it.at, 4'bxxxx, it.exp);
      end else begin
        chk(it.tag, {drvPos, drvNeg, fwdGate, syncGate}, it.exp);
      end
    end
  end

  initial begin
    rstN = 0; runEn = 1; periodStrobe = 0; pwmTerm = 0;
    encodeEn = 1; dutySel = 0; ovp = 0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", {drvPos, drvNeg, fwdGate, syncGate}, 4'b0000);
    ovp = 1; #1;
    chk("R1 ovp in reset", {drvPos, drvNeg, fwdGate, syncGate}, 4'b0000);
    ovp = 0;
    @(negedge clk);
    rstN = 1;
    repeat (2) @(negedge clk);
    chk("R1 before first strobe", {drvPos, drvNeg, fwdGate, syncGate}, 4'b0000);

    runPeriod(1, 0, 30, -1, "R4 mid window");
    runPeriod(1, 0, -1, -1, "R6 no request");
    runPeriod(1, 1, -1, -1, "R3 three-quarter duty");
    runPeriod(1, 0, 0, -1, "R5 zero duty");
    runPeriod(1, 0, 20, 40, "R7 second request positive");
    runPeriod(1, 0, 10, 70, "R7 request in negative half");
    runPeriod(1, 1, 70, -1, "R8 window cut at max duty");
    runPeriod(1, 0, 50, -1, "R3 request on max edge");
    runPeriod(1, 1, 1, -1, "R4 earliest request");
    runPeriod(0, 1, 40, -1, "R9 bypass three-quarter");
    runPeriod(0, 0, -1, -1, "R9 bypass no request");
    runPeriod(1, 0, 25, -1, "R2 back to encoded");

    // R10: overvoltage during on-time
    encodeEn = 1; dutySel = 0; periodStrobe = 1;
    @(negedge clk);
    periodStrobe = 0;
    repeat (5) @(negedge clk);
    chk("R2 on-time gates", {drvPos, drvNeg, fwdGate, syncGate}, 4'b1010);
    ovp = 1; #1;
    chk("R10 ovp forces gates", {1'b0, 1'b0, fwdGate, syncGate}, 4'b0001);
    ovp = 0; #1;
    chk("R10 ovp released", {1'b0, 1'b0, fwdGate, syncGate}, 4'b0010);
    repeat (PER) @(negedge clk);

    // R1: shutdown
    runEn = 0;
    repeat (2) @(negedge clk);
    chk("R1 shutdown", {drvPos, drvNeg, fwdGate, syncGate}, 4'b0000);
    ovp = 1; #1;
    chk("R1 ovp in shutdown", {drvPos, drvNeg, fwdGate, syncGate}, 4'b0000);
    ovp = 0;
    pwmTerm = 1; periodStrobe = 1;
    @(negedge clk);
    pwmTerm = 0; periodStrobe = 0;
    @(negedge clk);
    chk("R1 strobe ignored in shutdown", {drvPos, drvNeg, fwdGate, syncGate}, 4'b0000);
    runEn = 1;
    @(negedge clk);
    runPeriod(1, 1, 60, -1, "R2 restart after shutdown");

    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      nChecks++;
      nFail++;
      $display("FAIL R2: %0d items left, got %0d expected 0", sb.size(), sb.size());
    end
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule